// File: doc/BRIEF.md
# I2C Interrupt Vector Unit

This block gathers the event pulses produced by an I2C protocol engine and turns them into a single interrupt line plus a priority code that software can fetch. The engine reports seven kinds of events: arbitration lost, no-acknowledge, access ready, receive ready, transmit ready, stop detected and addressed-as-slave. Each pulse latches a pending flag. A mask register selects which flags may raise the interrupt and appear in the vector.

Software services the interrupt by reading the vector register again and again. Each read returns the code of the highest-priority enabled pending event and retires that event's flag, so the next read presents the next event. A read that returns zero means nothing is left to service. A status register exposes the error and handshake flags, which software clears by writing ones. It also shows a receive-shift-full level and a read-only bus-busy flag, which the unit tracks from start and stop detections.

The register port is a plain strobe interface. Reads are combinational and take effect at the clock edge on which the read strobe is high. The data registers of the controller are not part of the block. Only the strobes that retire the receive-ready and transmit-ready flags come in.

Top module: `i2c_irq_vector`

## Requirements
- R1: The mask register (address 1'b0 pair 2'b00) holds seven enable bits in positions 6:0, with bit k enabling event k (0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave). Higher bits are not stored and read as 0.
- R2: A pulse on `evt[k]` sets pending flag k whatever the mask is. The flag stays set until one of the clear sources in R5 to R7 retires it.
- R3: A read of the vector register (address 2'b10) returns code k+1 for the lowest k whose flag is both pending and enabled. Arbitration lost (code 1) therefore has the highest priority and addressed-as-slave (code 7) the lowest.
- R4: The vector read returns 0 when no flag is both pending and enabled. This includes the case where flags are pending but masked off.
- R5: A vector read that returns a nonzero code clears exactly that event's flag at the read edge. A read that returns 0 clears nothing.
- R6: The status register (address 2'b01) shows pending flags 0, 1, 2 and 5 in bits 0, 1, 2 and 5, whether or not they are masked. Writing a 1 to one of those bits clears that flag. Writing 0 leaves it unchanged. Written ones in any other bit position have no effect on any flag.
- R7: A pulse on `rx_data_rd` clears the receive-ready flag. A pulse on `tx_data_wr` clears the transmit-ready flag. Neither pulse affects the other flag.
- R8: Status bit 11 follows the `rx_shift_full` input. Status bit 12 (bus busy) sets on a `start_det` pulse and clears on a stop-detected event (`evt[5]`), with start winning if both arrive together. Writes cannot change bit 12.
- R9: `irq` is registered. One clock after any flag is both pending and enabled, `irq` is 1. One clock after none is, `irq` is 0.
- R10: When an event pulse and a clear of the same flag arrive in the same cycle, the flag stays set.
- R11: After reset, all flags, the mask, bus busy and `irq` are 0, so every register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (vector read has a side effect) |
| bus_addr | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 unused |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register |
| evt | input | 7 | Event pulses, bit k is event k as listed in R1 |
| start_det | input | 1 | Start condition detected pulse |
| rx_data_rd | input | 1 | Receive data register was read |
| tx_data_wr | input | 1 | Transmit data register was written |
| rx_shift_full | input | 1 | Receive shift register full level |
| irq | output | 1 | Registered interrupt request |

## Verification
Every one of the 127 nonzero event patterns is raised with all events enabled. The vector is then drained until it reads zero, which shows that the codes come out strictly in ascending order and that each read retires only its own flag. A second sweep raises all seven events under each of the 128 masks. It checks that masked flags never reach the vector or `irq` and that they survive in the status register after the zero read. Directed sequences cover the remaining cases: status writes with ones in bits that do not clear anything, the receive and transmit clear strobes applied against each other, simultaneous set and clear, and the bus-busy start/stop tracking.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

  localparam int NUM_EV = 7;
  localparam int CODE_W = $clog2(NUM_EV + 1);

  localparam int EV_ARB   = 0;
  localparam int EV_NACK  = 1;
  localparam int EV_ARDY  = 2;
  localparam int EV_RXRDY = 3;
  localparam int EV_TXRDY = 4;
  localparam int EV_STOP  = 5;
  localparam int EV_SLV   = 6;

  // flags visible and write-one-clearable in the status word
  localparam logic [NUM_EV-1:0] W1C_SET =
    (NUM_EV'(1) << EV_ARB) | (NUM_EV'(1) << EV_NACK) |
    (NUM_EV'(1) << EV_ARDY) | (NUM_EV'(1) << EV_STOP);

  localparam int ST_RSFULL = 11;
  localparam int ST_BUSY   = 12;
  localparam int STAT_W    = ST_BUSY + 1;

  typedef enum logic [1:0] {
    RA_MASK = 2'd0,
    RA_STAT = 2'd1,
    RA_VEC  = 2'd2,
    RA_NONE = 2'd3
  } reg_sel_e;

  // lowest set bit index plus one, zero when empty
  function automatic logic [CODE_W-1:0] lowest_code(input logic [NUM_EV-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction

  // one-hot flag select for a code, zero code selects nothing
  function automatic logic [NUM_EV-1:0] code_onehot(input logic [CODE_W-1:0] c);
    logic [NUM_EV-1:0] o;
    o = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      if (c == CODE_W'(i + 1)) o[i] = 1'b1;
    end
    return o;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [NUM_EV-1:0] flags,
                                                    input logic rsfull,
                                                    input logic busy);
    logic [STAT_W-1:0] s;
    s = '0;
    s[NUM_EV-1:0] = flags & W1C_SET;
    s[ST_RSFULL]  = rsfull;
    s[ST_BUSY]    = busy;
    return s;
  endfunction

endpackage

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[gi] <= 1'b0;
      else if (set_i[gi])  flag_q[gi] <= 1'b1;
      else if (clr_i[gi])  flag_q[gi] <= 1'b0;
    end

    // R2 / R10: a set pulse always lands, even against a clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[gi] |=> flag_q[gi]);

    // R5 / R6 / R7: any clear source without a set retires the flag
    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[gi] && !set_i[gi]) |=> !flag_q[gi]);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ivu_prio_enc.sv
module ivu_prio_enc
  import ivu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] pend_i,
  input  logic [NUM_EV-1:0] en_i,
  output logic [CODE_W-1:0] code_o
);

  logic [NUM_EV-1:0] live;

  assign live   = pend_i & en_i;
  assign code_o = lowest_code(live);

  // R4: zero code exactly when nothing enabled is pending
  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == '0) == (live == '0));

  // R3: reported event is live and nothing below it is
  assert_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != '0) |->
      (live[code_o - 1'b1] &&
       ((live & ((NUM_EV'(1) << (code_o - 1'b1)) - NUM_EV'(1))) == '0)));

endmodule

// File: rtl/ivu_busy_trk.sv
module ivu_busy_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);

  logic busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_i) busy_q <= 1'b1;
    else if (stop_i)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);

  assert_busy_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !busy_o);

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import ivu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_EV-1:0] evt,
  input  logic              start_det,
  input  logic              rx_data_rd,
  input  logic              tx_data_wr,
  input  logic              rx_shift_full,
  output logic              irq
);

  reg_sel_e          sel;
  logic              mask_wr, stat_wr, vec_rd;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] flags;
  logic [CODE_W-1:0] vec_code;
  logic [NUM_EV-1:0] clr_w1c, clr_vec, clr_data, clr_all;
  logic              busy;
  logic              irq_q;
  logic              unused_wdata;

  assign sel     = reg_sel_e'(bus_addr);
  assign mask_wr = bus_wr && (sel == RA_MASK);
  assign stat_wr = bus_wr && (sel == RA_STAT);
  assign vec_rd  = bus_rd && (sel == RA_VEC);
  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_EV];

  // mask register
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata[NUM_EV-1:0];
  end

  // clear sources, named for the assertions
  assign clr_w1c  = stat_wr ? (bus_wdata[NUM_EV-1:0] & W1C_SET) : '0;
  assign clr_vec  = vec_rd ? code_onehot(vec_code) : '0;
  assign clr_data = ((NUM_EV'(rx_data_rd)) << EV_RXRDY) |
                    ((NUM_EV'(tx_data_wr)) << EV_TXRDY);
  assign clr_all  = clr_w1c | clr_vec | clr_data;

  ivu_flag_bank #(.N(NUM_EV)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt),
    .clr_i  (clr_all),
    .flag_o (flags)
  );

  ivu_prio_enc u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (flags),
    .en_i   (mask_q),
    .code_o (vec_code)
  );

  ivu_busy_trk u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_det),
    .stop_i  (evt[EV_STOP]),
    .busy_o  (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flags & mask_q);
  end
  assign irq = irq_q;

  always_comb begin
    unique case (sel)
      RA_MASK: bus_rdata = DATA_W'(mask_q);
      RA_STAT: bus_rdata = DATA_W'(pack_status(flags, rx_shift_full, busy));
      RA_VEC:  bus_rdata = DATA_W'(vec_code);
      default: bus_rdata = '0;
    endcase
  end

  assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(bus_wdata[NUM_EV-1:0])));

  assert_irq_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & mask_q)) |=> irq);

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & mask_q)) |=> !irq);

  // R5: a zero vector read leaves every flag alone
  assert_zero_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_code == '0) |-> (clr_vec == '0));

endmodule

// File: tb/sim_i2c_irq_vector.sv
module sim_i2c_irq_vector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [6:0]  evt = 7'd0;
  logic        start_det = 1'b0, rx_data_rd = 1'b0, tx_data_wr = 1'b0;
  logic        rx_shift_full = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  i2c_irq_vector #(.DATA_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt(evt), .start_det(start_det), .rx_data_rd(rx_data_rd),
    .tx_data_wr(tx_data_wr), .rx_shift_full(rx_shift_full), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // first set bit from the bottom, plus one
  function automatic int exp_code(input int v);
    int k = 0;
    while (k < 7 && ((v >> k) & 1) == 0) k++;
    return (k == 7) ? 0 : k + 1;
  endfunction

  task automatic do_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic strobe(input logic [6:0] e, input logic st, input logic rr, input logic tw);
    @(negedge clk); evt = e; start_det = st; rx_data_rd = rr; tx_data_wr = tw;
    @(negedge clk); evt = '0; start_det = 0; rx_data_rd = 0; tx_data_wr = 0;
  endtask

  task automatic drain_check(input int pend, input int m, input string req);
    logic [15:0] d;
    int left = pend & m;
    for (int n = 0; n < 9; n++) begin
      int c = exp_code(left);
      do_rd(2'd2, d);
      chk(req, d, 16'(c));
      if (c == 0) break;
      left &= ~(1 << (c - 1));
    end
  endtask

  task automatic cleanup;
    logic [15:0] d;
    do_wr(2'd0, 16'h007F);
    for (int n = 0; n < 9; n++) begin
      do_rd(2'd2, d);
      if (d == 0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11 irq", {15'd0, irq}, 16'd0);
    do_rd(2'd0, d); chk("R11 mask", d, 16'd0);
    do_rd(2'd1, d); chk("R11 status", d, 16'd0);
    do_rd(2'd2, d); chk("R11 vector", d, 16'd0);
    do_rd(2'd3, d); chk("R11 unused addr", d, 16'd0);

    // R1 mask storage
    do_wr(2'd0, 16'hFFFF); do_rd(2'd0, d); chk("R1 mask upper", d, 16'h007F);
    do_wr(2'd0, 16'h002A); do_rd(2'd0, d); chk("R1 mask pattern", d, 16'h002A);

    // R2 R3 R5 R9: every pattern, all enabled
    for (int p = 1; p < 128; p++) begin
      do_wr(2'd0, 16'h007F);
      strobe(7'(p), 0, 0, 0);
      chk("R9 irq lags", {15'd0, irq}, 16'd0);
      @(negedge clk);
      chk("R9 irq raised", {15'd0, irq}, 16'd1);
      do_rd(2'd1, d); chk("R2 status flags", d, 16'(p & 32'h27));
      drain_check(p, 32'h7F, "R3 R5 drain order");
      chk("R9 irq dropped", {15'd0, irq}, 16'd0);
    end

    // R4 R6 R9: all events, every mask
    for (int m = 0; m < 128; m++) begin
      do_wr(2'd0, 16'(m));
      strobe(7'h7F, 0, 0, 0);
      @(negedge clk);
      chk("R9 irq vs mask", {15'd0, irq}, 16'(m != 0));
      drain_check(32'h7F, m, "R4 masked drain");
      do_rd(2'd1, d); chk("R4 R5 masked kept", d, 16'(32'h27 & ~m));
      cleanup();
    end

    // R6 write-one-clear
    do_wr(2'd0, 16'h0000);
    strobe(7'h7F, 0, 0, 0);
    do_wr(2'd1, 16'h0001); do_rd(2'd1, d); chk("R6 clear bit0", d, 16'h0026);
    do_wr(2'd1, 16'h0000); do_rd(2'd1, d); chk("R6 zero write", d, 16'h0026);
    do_wr(2'd1, 16'hFFD8); do_rd(2'd1, d); chk("R6 other bits", d, 16'h0026);
    do_wr(2'd0, 16'h0058);
    drain_check(32'h58, 32'h58, "R6 untouched flags");
    do_wr(2'd1, 16'h0024); do_rd(2'd1, d); chk("R6 clear 2 and 5", d, 16'h0002);
    do_wr(2'd1, 16'h0002); do_rd(2'd1, d); chk("R6 clear bit1", d, 16'h0000);
    cleanup();

    // R7 data strobes
    do_wr(2'd0, 16'h0018);
    strobe(7'h18, 0, 0, 0);
    strobe(7'h00, 0, 1, 0);
    do_rd(2'd2, d); chk("R7 rx strobe clears rx", d, 16'd5);
    do_rd(2'd2, d); chk("R7 empty", d, 16'd0);
    strobe(7'h10, 0, 0, 0);
    strobe(7'h00, 0, 0, 1);
    do_rd(2'd2, d); chk("R7 tx strobe clears tx", d, 16'd0);
    strobe(7'h08, 0, 0, 0);
    strobe(7'h00, 0, 0, 1);
    do_rd(2'd2, d); chk("R7 tx strobe keeps rx", d, 16'd4);
    do_rd(2'd2, d); chk("R7 empty again", d, 16'd0);

    // R10 set wins
    do_wr(2'd0, 16'h0001);
    @(negedge clk); bus_wr = 1; bus_addr = 2'd1; bus_wdata = 16'h0001; evt = 7'h01;
    @(negedge clk); bus_wr = 0; evt = '0;
    do_rd(2'd1, d); chk("R10 w1c vs set", d, 16'h0001);
    @(negedge clk); bus_rd = 1; bus_addr = 2'd2; evt = 7'h01;
    #1 d = bus_rdata; chk("R10 read code", d, 16'd1);
    @(negedge clk); bus_rd = 0; evt = '0;
    do_rd(2'd2, d); chk("R10 vector read vs set", d, 16'd1);
    do_rd(2'd2, d); chk("R10 drained", d, 16'd0);
    cleanup();

    // R8 bus busy and shift full
    do_wr(2'd0, 16'h0000);
    strobe(7'h00, 1, 0, 0);
    do_rd(2'd1, d); chk("R8 busy set", d, 16'h1000);
    do_wr(2'd1, 16'h1000); do_rd(2'd1, d); chk("R8 busy read-only", d, 16'h1000);
    rx_shift_full = 1'b1;
    do_rd(2'd1, d); chk("R8 shift full", d, 16'h1800);
    rx_shift_full = 1'b0;
    strobe(7'h20, 1, 0, 0);
    do_rd(2'd1, d); chk("R8 start beats stop", d, 16'h1020);
    strobe(7'h20, 0, 0, 0);
    do_rd(2'd1, d); chk("R8 busy cleared", d, 16'h0020);
    do_wr(2'd1, 16'h0020); do_rd(2'd1, d); chk("R8 R6 final", d, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule